// File: doc/BRIEF.md
# Supervisor Reset and Watchdog Controller

This block produces the system reset for a processor subsystem. Three events assert it: the power-on reset of the block itself, a drop of the supply-good flag from an external comparator, and expiry of a watchdog that software must restart at regular intervals. Each event holds the reset active for a fixed hold period before release. For a supply drop, the hold period runs only after the flag has come back. The reset is driven in both polarities at once.

A free-running millisecond timebase times both the hold period and the watchdog interval. The parameter `CLK_PER_MS` gives the number of clocks in one millisecond. The watchdog interval comes from a 2-bit select that another block has already latched. The controller samples that select once, on the first clock after the power-on reset. It then ignores every later change of the select until the next power-on reset. Analog threshold comparison and the storage of the select value are not part of this block.

Top module: `sup_rst_wdog`

## Requirements
- R1: After `rst` is released, `sys_rst_o` stays high for `HOLD_MS` milliseconds of the timebase and then goes low. The bench accepts a window of one millisecond for the tick phase.
- R2: `sys_rst_n_o` is at all times the inverse of `sys_rst_o`, including during `rst`.
- R3: When `supply_ok_i` is low at a clock edge, `sys_rst_o` is high after that edge. It stays high for as long as `supply_ok_i` stays low.
- R4: After `supply_ok_i` returns high, `sys_rst_o` stays high for a further `HOLD_MS` milliseconds (one-millisecond window) and then goes low.
- R5: The select encodes the watchdog interval as follows: 2'b00 is `WD_SHORT_MS` (200 ms), 2'b01 is `WD_MID_MS` (600 ms) and 2'b10 is `WD_LONG_MS` (1400 ms). Without a kick, `sys_rst_o` goes high once that interval has passed after reset release (one-millisecond window).
- R6: Select value 2'b11 disables the watchdog, so `sys_rst_o` never rises without a kick.
- R7: A one-cycle pulse on `kick_i` restarts the watchdog interval. Kicks spaced more closely than the interval keep `sys_rst_o` low. After the last kick, expiry follows one full interval later.
- R8: The select is captured on the first clock after `rst` is released. A later change of `wd_sel_i` has no effect on the interval until the next `rst`.
- R9: A watchdog expiry holds `sys_rst_o` high for `HOLD_MS`. The watchdog counter stays cleared while reset is active. After release, the full interval starts again from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset; also reopens the select capture |
| supply_ok_i | input | 1 | Supply-good flag from the comparator, high when the supply is adequate |
| kick_i | input | 1 | One-cycle watchdog restart strobe |
| wd_sel_i | input | 2 | Watchdog interval select (00 short, 01 mid, 10 long, 11 off) |
| sys_rst_o | output | 1 | System reset, active high |
| sys_rst_n_o | output | 1 | System reset, active low |

## Verification
The bench runs the block with a timebase of four clocks per millisecond. It measures, in clocks, each high and each low stretch of the reset output. Each select value is tried in turn. The three timed codes must each land in their own one-millisecond window, which separates them from each other. The disabled code must produce no reset at all. Two more runs cover the select rules. In one, the select is changed while the block runs, and the following interval must keep the old length. In the other, kicks at 150 ms spacing must hold the reset off for ten periods, and an expiry must follow one interval after the last kick. A supply drop in mid-operation checks the immediate assertion, the hold while the flag stays low, and the recovery hold.

// File: rtl/sup_pkg.sv
package sup_pkg;

    typedef enum logic [1:0] {
        WD_SHORT = 2'b00,
        WD_MID   = 2'b01,
        WD_LONG  = 2'b10,
        WD_OFF   = 2'b11
    } wd_sel_e;

    typedef struct packed {
        logic brown;
        logic wd;
    } rst_cause_t;

    function automatic int unsigned cnt_width(input int unsigned max_val);
        return (max_val > 1) ? $clog2(max_val + 1) : 1;
    endfunction

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/sup_tick_gen.sv
module sup_tick_gen #(
    parameter int unsigned CLK_PER_MS = 1000
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);
    generate
        if (CLK_PER_MS <= 1) begin : g_every
            assign tick_o = 1'b1;
        end else begin : g_div
            localparam int unsigned W = sup_pkg::cnt_width(CLK_PER_MS - 1);
            localparam logic [W-1:0] LAST = W'(CLK_PER_MS - 1);
            logic [W-1:0] cnt_q;

            always_ff @(posedge clk) begin
                if (rst || cnt_q == LAST) cnt_q <= '0;
                else                      cnt_q <= cnt_q + 1'b1;
            end

            assign tick_o = (cnt_q == LAST);

            AST_TICK_RANGE: assert property (@(posedge clk) disable iff (rst)
                cnt_q <= LAST);  // R1
        end
    endgenerate
endmodule

// File: rtl/sup_hold_timer.sv
module sup_hold_timer
    import sup_pkg::*;
#(
    parameter int unsigned HOLD_MS = 200
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_i,
    input  rst_cause_t cause_i,
    output logic       act_o
);
    localparam int unsigned HW = cnt_width(HOLD_MS);
    localparam logic [HW-1:0] LAST = HW'(HOLD_MS - 1);

    logic          act_q;
    logic [HW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || cause_i.brown || cause_i.wd) begin
            act_q <= 1'b1;
            cnt_q <= '0;
        end else if (act_q && tick_i) begin
            if (cnt_q == LAST) begin
                act_q <= 1'b0;
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign act_o = act_q;

    AST_BROWN_ASSERTS: assert property (@(posedge clk) disable iff (rst)
        cause_i.brown |=> act_q);  // R3
    AST_RELEASE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        $fell(act_q) |-> $past(tick_i) && !$past(cause_i.brown));  // R4
    AST_HOLD_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);  // R1
    AST_WD_ASSERTS: assert property (@(posedge clk) disable iff (rst)
        cause_i.wd |=> act_q);  // R9
endmodule

// File: rtl/sup_wdog.sv
module sup_wdog
    import sup_pkg::*;
#(
    parameter int unsigned T_SHORT_MS = 200,
    parameter int unsigned T_MID_MS   = 600,
    parameter int unsigned T_LONG_MS  = 1400
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_i,
    input  logic       hold_i,
    input  logic       kick_i,
    input  logic [1:0] sel_i,
    output logic       expire_o
);
    localparam int unsigned CW = cnt_width(max3(T_SHORT_MS, T_MID_MS, T_LONG_MS));
    localparam logic [CW-1:0] LIM_S = CW'(T_SHORT_MS - 1);
    localparam logic [CW-1:0] LIM_M = CW'(T_MID_MS - 1);
    localparam logic [CW-1:0] LIM_L = CW'(T_LONG_MS - 1);

    wd_sel_e       mode_q;
    logic          locked_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last;
    logic          run;
    logic          at_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= WD_OFF;
            locked_q <= 1'b0;
        end else if (!locked_q) begin
            mode_q   <= wd_sel_e'(sel_i);
            locked_q <= 1'b1;
        end
    end

    always_comb begin
        case (mode_q)
            WD_SHORT: last = LIM_S;
            WD_MID:   last = LIM_M;
            WD_LONG:  last = LIM_L;
            default:  last = LIM_L;
        endcase
    end

    assign run    = locked_q && !hold_i && (mode_q != WD_OFF);
    assign at_end = (cnt_q == last);

    always_ff @(posedge clk) begin
        if (rst || !run || kick_i)  cnt_q <= '0;
        else if (tick_i) cnt_q <= at_end ? '0 : cnt_q + 1'b1;
    end

    assign expire_o = run && tick_i && !kick_i && at_end;

    AST_MODE_STICKY: assert property (@(posedge clk) disable iff (rst)
        $past(locked_q) |-> $stable(mode_q));  // R8
    AST_OFF_NO_EXPIRE: assert property (@(posedge clk) disable iff (rst)
        (mode_q == WD_OFF) |-> !expire_o);  // R6
    AST_KICK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        kick_i |=> (cnt_q == '0));  // R7
    AST_IDLE_IN_RESET: assert property (@(posedge clk) disable iff (rst)
        hold_i |=> (cnt_q == '0));  // R9
    AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= last);  // R5
endmodule

// File: rtl/sup_rst_wdog.sv
module sup_rst_wdog
    import sup_pkg::*;
#(
    parameter int unsigned CLK_PER_MS  = 1000,
    parameter int unsigned HOLD_MS     = 200,
    parameter int unsigned WD_SHORT_MS = 200,
    parameter int unsigned WD_MID_MS   = 600,
    parameter int unsigned WD_LONG_MS  = 1400
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       supply_ok_i,
    input  logic       kick_i,
    input  logic [1:0] wd_sel_i,
    output logic       sys_rst_o,
    output logic       sys_rst_n_o
);
    logic       tick;
    logic       hold;
    logic       expire;
    rst_cause_t cause;

    sup_tick_gen #(.CLK_PER_MS(CLK_PER_MS)) i_tick (
        .clk   (clk),
        .rst   (rst),
        .tick_o(tick)
    );

    assign cause.brown = !supply_ok_i;
    assign cause.wd    = expire;

    sup_hold_timer #(.HOLD_MS(HOLD_MS)) i_hold (
        .clk    (clk),
        .rst    (rst),
        .tick_i (tick),
        .cause_i(cause),
        .act_o  (hold)
    );

    sup_wdog #(
        .T_SHORT_MS(WD_SHORT_MS),
        .T_MID_MS  (WD_MID_MS),
        .T_LONG_MS (WD_LONG_MS)
    ) i_wdog (
        .clk     (clk),
        .rst     (rst),
        .tick_i  (tick),
        .hold_i  (hold),
        .kick_i  (kick_i),
        .sel_i   (wd_sel_i),
        .expire_o(expire)
    );

    assign sys_rst_o   = hold;
    assign sys_rst_n_o = !hold;
endmodule

// File: tb/test_sup_rst_wdog.sv
`timescale 1ns/1ps
module test_sup_rst_wdog;
    localparam int CPM  = 4;
    localparam int HOLD = 200;
    localparam int TS   = 200;
    localparam int TM   = 600;
    localparam int TL   = 1400;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       supply_ok = 1'b1;
    logic       kick = 1'b0;
    logic [1:0] sel = 2'b00;
    logic       sys_rst, sys_rst_n;

    int checks = 0;
    int errors = 0;
    int comp_bad = 0;

    always #2 clk = ~clk;

    sup_rst_wdog #(
        .CLK_PER_MS(CPM), .HOLD_MS(HOLD),
        .WD_SHORT_MS(TS), .WD_MID_MS(TM), .WD_LONG_MS(TL)
    ) i_sup_rst_wdog (
        .clk(clk), .rst(rst), .supply_ok_i(supply_ok), .kick_i(kick),
        .wd_sel_i(sel), .sys_rst_o(sys_rst), .sys_rst_n_o(sys_rst_n)
    );

    task automatic chk(input bit ok, input string req, input int act,
                       input int lo, input int hi);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=[%0d..%0d]", req, act, lo, hi);
        end
    endtask

    task automatic chk_win(input string req, input int n, input int ms);
        int lo = (ms - 1) * CPM - 1;
        int hi = ms * CPM + 1;
        chk(n >= lo && n <= hi, req, n, lo, hi);
    endtask

    // count consecutive negedge samples at level lvl, stop at change or cap
    task automatic run_level(input logic lvl, input int cap, output int n);
        n = 0;
        while (n < cap) begin
            @(negedge clk);
            if (sys_rst_n !== ~sys_rst) comp_bad++;
            if (sys_rst !== lvl) break;
            n++;
        end
    endtask

    task automatic power_on(input logic [1:0] s);
        @(negedge clk);
        rst = 1'b1;
        sel = s;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R1 actual=hung expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n;
        int cap;
        // reset state
        repeat (3) @(negedge clk);
        chk(sys_rst === 1'b1, "R1 reset state high", int'(sys_rst), 1, 1);
        chk(sys_rst_n === 1'b0, "R2 reset state low-active", int'(sys_rst_n), 0, 0);

        // short interval, expiry, sticky select, restart
        power_on(2'b00);
        run_level(1'b1, 10000, n); chk_win("R1 power-on hold", n, HOLD);
        run_level(1'b0, 10000, n); chk_win("R5 sel 00 interval", n, TS);
        sel = 2'b10;  // must be ignored (R8)
        run_level(1'b1, 10000, n); chk_win("R9 expiry hold", n, HOLD);
        run_level(1'b0, 10000, n); chk_win("R8 interval after sel change", n, TS);
        run_level(1'b1, 10000, n); chk_win("R9 second expiry hold", n, HOLD);

        // mid interval
        power_on(2'b01);
        run_level(1'b1, 10000, n); chk_win("R1 power-on hold sel 01", n, HOLD);
        run_level(1'b0, 10000, n); chk_win("R5 sel 01 interval", n, TM);

        // long interval
        power_on(2'b10);
        run_level(1'b1, 10000, n); chk_win("R1 power-on hold sel 10", n, HOLD);
        run_level(1'b0, 10000, n); chk_win("R5 sel 10 interval", n, TL);

        // kicks
        power_on(2'b00);
        run_level(1'b1, 10000, n);
        cap = 0;
        for (int k = 0; k < 10; k++) begin
            repeat (150 * CPM) begin
                @(negedge clk);
                if (sys_rst !== 1'b0) cap++;
            end
            kick = 1'b1;
            @(negedge clk);
            kick = 1'b0;
        end
        chk(cap == 0, "R7 kicked watchdog stays quiet", cap, 0, 0);
        run_level(1'b0, 10000, n); chk_win("R7 interval after last kick", n + 1, TS);

        // supply drop in mid-operation
        power_on(2'b00);
        run_level(1'b1, 10000, n);
        repeat (100) @(negedge clk);
        supply_ok = 1'b0;
        @(negedge clk);
        chk(sys_rst === 1'b1, "R3 immediate assert", int'(sys_rst), 1, 1);
        cap = 0;
        repeat (60 * CPM) begin
            @(negedge clk);
            if (sys_rst !== 1'b1) cap++;
        end
        chk(cap == 0, "R3 held while supply low", cap, 0, 0);
        supply_ok = 1'b1;
        run_level(1'b1, 10000, n); chk_win("R4 recovery hold", n + 1, HOLD);

        // disabled
        power_on(2'b11);
        run_level(1'b1, 10000, n); chk_win("R1 power-on hold sel 11", n, HOLD);
        sel = 2'b00;  // ignored (R8)
        run_level(1'b0, 2000 * CPM, n);
        chk(n == 2000 * CPM, "R6 disabled never expires", n, 2000 * CPM, 2000 * CPM);

        chk(comp_bad == 0, "R2 outputs complementary", comp_bad, 0, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule